// File: doc/BRIEF.md
# Text cursor shape decoder

This block converts the two cursor-shape register values of a character display controller into one or two vertical cursor segments inside a character cell. Each segment is given as a first scan line and a height in scan lines. The inputs are an 8-bit start register, a 5-bit end register, the cell height and the largest scan line a cursor may use. The outputs are a visible flag, two (first line, height) pairs and a one-clock pulse that marks each fresh result. Drawing and blinking the cursor are handled elsewhere.

The block holds its own copy of the two register values. A recomputation starts only when the value on the start or end input differs from that copy. A change to the cell height or to the maximum line alone does not start one. The controller has two states. `CS_WAIT` stays in place ("idle hold") while both registers match their copies. On a mismatch it loads the copies and moves to `CS_EVAL` ("capture"). `CS_EVAL` registers the decoded shape, raises the pulse and always returns to `CS_WAIT` ("publish").

Top module: `cursor_shape_top`

## Requirements
- R1: After reset, `vis_o`, both segment starts, both heights and `chg_o` are all 0, and the held register copies are 0.
- R2: When `start_i` or `end_i` differs from the held copy at a rising edge, the new shape appears on the outputs one edge later. `chg_o` is high for the cycle after that second edge. If neither register differs (the same value is written again, or only `char_h_i` or `max_line_i` changes), there is no pulse and the outputs do not change.
- R3: `chg_o` is never high for two cycles in a row.
- R4: If bit 5 of `start_i` is set, or `start_i` (all 8 bits) is greater than `max_line_i`, then `vis_o` is 0 and all four segment fields are 0.
- R5: Otherwise `vis_o` is 1, and the effective start is `start_i[4:0]`. If `end_i` is greater than `max_line_i`, the cursor is a block: segment 0 is (0, `max_line_i`) and segment 1 is (0, 0).
- R6: Otherwise, if the effective start is less than or equal to `end_i`, segment 0 is (start, `end_i` − start + 1) and segment 1 is (0, 0).
- R7: Otherwise the cursor wraps. Segment 0 is (0, `end_i`) and segment 1 is (start, `char_h_i` − start).
- R8: The checks are applied in a fixed priority: R4 first, then the block case of R5, then R6 or R7. Segment 1 is cleared to (0, 0) by every recomputation that does not end in a wrap.
- R9: A register change that arrives while `CS_EVAL` is publishing an earlier value is not lost. The earlier result is published first, and the new one two edges later with its own pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 8 | Cursor start register value |
| end_i | input | 5 | Cursor end register value |
| char_h_i | input | 6 | Character cell height in scan lines |
| max_line_i | input | 5 | Largest scan line the cursor may use |
| vis_o | output | 1 | Cursor visible |
| s0_start_o | output | 5 | Segment 0 first scan line |
| s0_hgt_o | output | 6 | Segment 0 height |
| s1_start_o | output | 5 | Segment 1 first scan line |
| s1_hgt_o | output | 6 | Segment 1 height |
| chg_o | output | 1 | One-cycle pulse after each recomputation |

## Verification
Two functions can fall in the same cycle. Publishing one result in `CS_EVAL` can coincide with the arrival of a new register value. The bench provokes this by changing `start_i` and `end_i` in the cycle where the controller is in `CS_EVAL`. It checks that the first shape appears with its pulse, then that the second shape appears two edges later with a separate pulse. Both shapes are compared against the arithmetic of the requirements. Separately, an exhaustive sweep of start and end values under two height and maximum settings judges the decode priority and every segment case.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
    typedef enum logic [0:0] {
        CS_WAIT = 1'b0,
        CS_EVAL = 1'b1
    } cs_state_e;
endpackage

// File: rtl/cursor_shape_calc.sv
module cursor_shape_calc #(
    parameter int REG_W  = 8,
    parameter int LINE_W = 5
) (
    input  logic [REG_W-1:0]  start_i,
    input  logic [LINE_W-1:0] end_i,
    input  logic [LINE_W:0]   char_h_i,
    input  logic [LINE_W-1:0] max_line_i,
    output logic              vis_o,
    output logic [LINE_W-1:0] s0_start_o,
    output logic [LINE_W:0]   s0_hgt_o,
    output logic [LINE_W-1:0] s1_start_o,
    output logic [LINE_W:0]   s1_hgt_o
);
    localparam int HIDE_BIT = LINE_W;

    logic [LINE_W-1:0] eff_start;
    logic              hidden;

    assign eff_start = start_i[LINE_W-1:0];
    assign hidden    = start_i[HIDE_BIT] || (start_i > REG_W'(max_line_i));

    always_comb begin
        vis_o      = 1'b0;
        s0_start_o = '0;
        s0_hgt_o   = '0;
        s1_start_o = '0;
        s1_hgt_o   = '0;
        if (!hidden) begin
            vis_o = 1'b1;
            if (end_i > max_line_i) begin
                s0_hgt_o = {1'b0, max_line_i};
            end else if (eff_start <= end_i) begin
                s0_start_o = eff_start;
                s0_hgt_o   = {1'b0, end_i} - {1'b0, eff_start} + 1'b1;
            end else begin
                s0_hgt_o   = {1'b0, end_i};
                s1_start_o = eff_start;
                s1_hgt_o   = char_h_i - {1'b0, eff_start};
            end
        end
    end
endmodule

// File: rtl/cursor_seq.sv
module cursor_seq
    import cursor_pkg::*;
#(
    parameter int REG_W  = 8,
    parameter int LINE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  start_i,
    input  logic [LINE_W-1:0] end_i,
    output logic [REG_W-1:0]  held_start_o,
    output logic [LINE_W-1:0] held_end_o,
    input  logic              d_vis,
    input  logic [LINE_W-1:0] d_s0_start,
    input  logic [LINE_W:0]   d_s0_hgt,
    input  logic [LINE_W-1:0] d_s1_start,
    input  logic [LINE_W:0]   d_s1_hgt,
    output logic              vis_o,
    output logic [LINE_W-1:0] s0_start_o,
    output logic [LINE_W:0]   s0_hgt_o,
    output logic [LINE_W-1:0] s1_start_o,
    output logic [LINE_W:0]   s1_hgt_o,
    output logic              chg_o
);
    cs_state_e st_q, st_d;
    logic      differs;

    assign differs = (start_i != held_start_o) || (end_i != held_end_o);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CS_WAIT: if (differs) st_d = CS_EVAL;
            CS_EVAL: st_d = CS_WAIT;
            default: st_d = CS_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CS_WAIT;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_start_o <= '0;
            held_end_o   <= '0;
            vis_o        <= 1'b0;
            s0_start_o   <= '0;
            s0_hgt_o     <= '0;
            s1_start_o   <= '0;
            s1_hgt_o     <= '0;
            chg_o        <= 1'b0;
        end else begin
            chg_o <= (st_q == CS_EVAL);
            if (st_q == CS_WAIT && differs) begin
                held_start_o <= start_i;
                held_end_o   <= end_i;
            end
            if (st_q == CS_EVAL) begin
                vis_o      <= d_vis;
                s0_start_o <= d_s0_start;
                s0_hgt_o   <= d_s0_hgt;
                s1_start_o <= d_s1_start;
                s1_hgt_o   <= d_s1_hgt;
            end
        end
    end

    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        chg_o |=> !chg_o);

    assert_quiet_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !chg_o |-> ($stable(vis_o) && $stable(s0_start_o) && $stable(s0_hgt_o)
                    && $stable(s1_start_o) && $stable(s1_hgt_o)));

    assert_trigger_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CS_WAIT && differs) |=> ##1 chg_o);

    assert_hidden_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !vis_o |-> (s0_hgt_o == '0 && s1_hgt_o == '0));

    assert_wrap_layout_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_hgt_o != '0) |-> (vis_o && s0_start_o == '0));
endmodule

// File: rtl/cursor_shape_top.sv
module cursor_shape_top #(
    parameter int REG_W  = 8,
    parameter int LINE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  start_i,
    input  logic [LINE_W-1:0] end_i,
    input  logic [LINE_W:0]   char_h_i,
    input  logic [LINE_W-1:0] max_line_i,
    output logic              vis_o,
    output logic [LINE_W-1:0] s0_start_o,
    output logic [LINE_W:0]   s0_hgt_o,
    output logic [LINE_W-1:0] s1_start_o,
    output logic [LINE_W:0]   s1_hgt_o,
    output logic              chg_o
);
    logic [REG_W-1:0]  held_start;
    logic [LINE_W-1:0] held_end;
    logic              d_vis;
    logic [LINE_W-1:0] d_s0_start, d_s1_start;
    logic [LINE_W:0]   d_s0_hgt, d_s1_hgt;

    cursor_shape_calc #(.REG_W(REG_W), .LINE_W(LINE_W)) u_calc (
        .start_i    (held_start),
        .end_i      (held_end),
        .char_h_i   (char_h_i),
        .max_line_i (max_line_i),
        .vis_o      (d_vis),
        .s0_start_o (d_s0_start),
        .s0_hgt_o   (d_s0_hgt),
        .s1_start_o (d_s1_start),
        .s1_hgt_o   (d_s1_hgt)
    );

    cursor_seq #(.REG_W(REG_W), .LINE_W(LINE_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .end_i        (end_i),
        .held_start_o (held_start),
        .held_end_o   (held_end),
        .d_vis        (d_vis),
        .d_s0_start   (d_s0_start),
        .d_s0_hgt     (d_s0_hgt),
        .d_s1_start   (d_s1_start),
        .d_s1_hgt     (d_s1_hgt),
        .vis_o        (vis_o),
        .s0_start_o   (s0_start_o),
        .s0_hgt_o     (s0_hgt_o),
        .s1_start_o   (s1_start_o),
        .s1_hgt_o     (s1_hgt_o),
        .chg_o        (chg_o)
    );
endmodule

// File: tb/sim_cursor_shape_top.sv
`timescale 1ns/1ps
module sim_cursor_shape_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] start_i = '0;
    logic [4:0] end_i = '0;
    logic [5:0] char_h_i = 6'd16;
    logic [4:0] max_line_i = 5'd15;
    logic       vis_o, chg_o;
    logic [4:0] s0_start_o, s1_start_o;
    logic [5:0] s0_hgt_o, s1_hgt_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    cursor_shape_top u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .end_i(end_i),
        .char_h_i(char_h_i), .max_line_i(max_line_i), .vis_o(vis_o),
        .s0_start_o(s0_start_o), .s0_hgt_o(s0_hgt_o),
        .s1_start_o(s1_start_o), .s1_hgt_o(s1_hgt_o), .chg_o(chg_o)
    );

    function automatic logic [22:0] shape_now();
        return {vis_o, s0_start_o, s0_hgt_o, s1_start_o, s1_hgt_o};
    endfunction

    function automatic logic [22:0] model(input int s, input int e, input int ch, input int mx);
        int st;
        st = s % 32;
        if (((s / 32) % 2) == 1 || s > mx) return '0;
        if (e > mx) return {1'b1, 5'd0, 6'(mx), 5'd0, 6'd0};
        if (st <= e) return {1'b1, 5'(st), 6'(e - st + 1), 5'd0, 6'd0};
        return {1'b1, 5'd0, 6'(e), 5'(st), 6'(ch - st)};
    endfunction

    function automatic string tag_of(input int s, input int e, input int mx);
        if (((s / 32) % 2) == 1 || s > mx) return "R4";
        if (e > mx) return "R5";
        if ((s % 32) <= e) return "R6";
        return "R7 R8";
    endfunction

    task automatic chk(input string req, input logic [22:0] got, input logic [22:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic apply(input int s, input int e);
        logic [22:0] exp;
        exp = model(s, e, int'(char_h_i), int'(max_line_i));
        start_i = 8'(s);
        end_i   = 5'(e);
        @(negedge clk);
        chk("R2 no early pulse", {22'd0, chg_o}, 23'd0);
        @(negedge clk);
        chk("R2 pulse", {22'd0, chg_o}, 23'd1);
        chk(tag_of(s, e, int'(max_line_i)), shape_now(), exp);
        @(negedge clk);
        chk("R3 single pulse", {22'd0, chg_o}, 23'd0);
    endtask

    initial begin
        #900000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [22:0] snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset shape", shape_now(), 23'd0);
        chk("R1 reset pulse", {22'd0, chg_o}, 23'd0);

        apply(5, 3);
        for (int s = 0; s < 40; s++)
            for (int e = 0; e < 32; e++)
                apply(s, e);

        char_h_i = 6'd14; max_line_i = 5'd13;
        for (int s = 0; s < 40; s++)
            for (int e = 0; e < 32; e++)
                apply(s, e);

        apply(8'hC3, 2);
        apply(8'h47, 4);
        apply(8'h83, 9);

        // R2: same value again, or only height/max changes: no pulse, no change
        apply(6, 12);
        snap = shape_now();
        start_i = 8'd6; end_i = 5'd12;
        char_h_i = 6'd20; max_line_i = 5'd3;
        repeat (4) begin
            @(negedge clk);
            chk("R2 quiet pulse", {22'd0, chg_o}, 23'd0);
        end
        chk("R2 quiet shape", shape_now(), snap);
        char_h_i = 6'd16; max_line_i = 5'd15;

        // R9: new value arrives while the previous one is being published
        start_i = 8'd9; end_i = 5'd4;
        @(negedge clk);
        start_i = 8'd2; end_i = 5'd7;
        @(negedge clk);
        chk("R9 first pulse", {22'd0, chg_o}, 23'd1);
        chk("R9 first shape", shape_now(), model(9, 4, 16, 15));
        @(negedge clk);
        chk("R9 gap", {22'd0, chg_o}, 23'd0);
        @(negedge clk);
        chk("R9 second pulse", {22'd0, chg_o}, 23'd1);
        chk("R9 second shape", shape_now(), model(2, 7, 16, 15));

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule